// File: doc/BRIEF.md
# Camera Link acquisition front end

This block sits behind the Camera Link deserializer. It takes the parallel pixel words and the four framing flags (frame, line, data and spare valid), which arrive in the camera's pixel-clock domain. It turns each flag into an active-high signal according to its own polarity setting. It clears the ports that the selected tap configuration does not use. Each captured pixel cycle is then carried over an asynchronous FIFO with Gray-coded pointers into a faster image-data clock domain. On that side every word appears exactly once, marked by a single-cycle output-valid strobe. Cycles without the strobe carry no information.

Before any word is accepted, the block must lock onto the camera. Software sets the tap code, the per-flag polarities and the scan mode while the block is in reset, then raises the init input. It waits for the ready output and then lowers init again.

Lock needs two complete line-valid pulses. For an area-scan camera those two pulses must also follow a frame-valid rising edge, so that capture begins at a frame boundary. In line-scan mode the frame-valid flag plays no part in lock. Once locked, the block stays locked until reset.

Top module: `camlink_rx_front`

## Requirements
- R1: Data ports are packed with port A in `cam_data[7:0]`, port B in `[15:8]` and so on up to port J in `[79:72]`. With `cfg_taps` = 0 (Base), ports A, B and C pass through unchanged and ports D to J are output as zero.
- R2: With `cfg_taps` = 1 (Medium), ports A to F pass through and ports G to J are zero. With `cfg_taps` = 2 (Full/Extended/10-tap), all ten ports pass through.
- R3: Flag bits are ordered frame valid (bit 0), line valid (bit 1), data valid (bit 2), spare (bit 3) in both `cfg_pol` and `out_flags`. A `cfg_pol` bit of 1 marks that input flag as active high and 0 as active low. `out_flags` is always active high.
- R4: In area-scan mode (`cfg_linescan` = 0), `acq_ready` rises only after a frame-valid rising edge followed by two line-valid falling edges, all while init is high. If init is raised in the middle of a frame, ready stays low until the next frame has started. If frame valid never rises, ready stays low.
- R5: In line-scan mode, frame valid is ignored and two line-valid falling edges seen while init is high are enough to raise `acq_ready`.
- R6: If line valid never falls, `acq_ready` never rises.
- R7: Lowering `acq_init` before ready has risen clears the lock detection, and ready stays low. A later init restarts detection from scratch.
- R8: Once high, `acq_ready` stays high until reset, including after `acq_init` is lowered.
- R9: `out_valid` is never high while `acq_ready` is low, so nothing is output before lock.
- R10: After lock, every pixel cycle is output exactly once, in order, with one `out_valid` cycle per word and within 8 pixel cycles of its capture. The FIFO never fills.
- R11: After reset, `acq_ready` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Camera pixel clock |
| pix_rst_n | input | 1 | Synchronous active-low reset, pixel domain |
| cam_data | input | 80 | Ten 8-bit ports from the deserializer, port A lowest |
| cam_fval | input | 1 | Frame valid, polarity set by `cfg_pol[0]` |
| cam_lval | input | 1 | Line valid, polarity set by `cfg_pol[1]` |
| cam_dval | input | 1 | Data valid, polarity set by `cfg_pol[2]` |
| cam_spare | input | 1 | Spare flag, polarity set by `cfg_pol[3]` |
| cfg_taps | input | 2 | Tap configuration: 0 Base, 1 Medium, 2 Full |
| cfg_pol | input | 4 | Per-flag polarity, 1 = active high |
| cfg_linescan | input | 1 | 1 = line-scan camera (frame valid ignored for lock) |
| img_clk | input | 1 | Image-data clock, faster than `pix_clk` |
| img_rst_n | input | 1 | Synchronous active-low reset, image domain |
| acq_init | input | 1 | Starts lock detection while high |
| acq_ready | output | 1 | Lock achieved (image domain) |
| out_valid | output | 1 | Output word strobe, one cycle per captured pixel |
| out_data | output | 80 | Ten 8-bit ports, masked per tap configuration |
| out_flags | output | 4 | Active-high flags, same bit order as `cfg_pol` |

## Verification
The hardest state to reach is area-scan init raised in the middle of a frame. Several full line-valid pulses then go by that must not count towards lock, because no frame edge has yet been seen. The stimulus drives a free-running 64-pixel frame of 8-pixel lines and raises init at a fixed phase after the frame edge. It samples ready just before the next frame edge, where line-scan mode must already be locked and area-scan mode must not. A second hard case is the early drop of init. Init is held high for three pixel cycles, which is shorter than one line, so the lock counter is cleared before a single line ends. Init is then raised again to show that detection restarts.

// File: rtl/camlink_pkg.sv
// Package: shared constants and types for the Camera Link front end.
// Assumes: four framing flags, packed in the fixed order given below.
package camlink_pkg;
    localparam int NUM_FLAGS  = 4;
    localparam int FLAG_FVAL  = 0;
    localparam int FLAG_LVAL  = 1;
    localparam int FLAG_DVAL  = 2;
    localparam int FLAG_SPARE = 3;

    // Number of ports carried by the two narrower tap configurations.
    localparam int BASE_PORTS   = 3;
    localparam int MEDIUM_PORTS = 6;

    typedef enum logic [1:0] {
        TAPS_BASE   = 2'd0,
        TAPS_MEDIUM = 2'd1,
        TAPS_FULL   = 2'd2
    } tap_cfg_e;

    typedef enum logic [1:0] {
        LK_IDLE   = 2'd0,
        LK_SEEK   = 2'd1,
        LK_LOCKED = 2'd2
    } lock_state_e;
endpackage

// File: rtl/camlink_sync.sv
// Module: multi-flop synchroniser for a level or a Gray-coded vector.
// Assumes: at most one bit of d changes per source clock (Gray code or single bit),
// and STAGES >= 2.
module camlink_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int CHAIN_W = WIDTH * STAGES;

    logic [CHAIN_W-1:0] chain;

    // Shift the asynchronous input through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[CHAIN_W-WIDTH-1:0], d};
        end
    end

    assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/camlink_flag_norm.sv
// Module: turns each raw framing flag into an active-high flag.
// Assumes: pol[i] = 1 means flag i is active high on the cable; held static.
module camlink_flag_norm
    import camlink_pkg::*;
(
    input  logic [NUM_FLAGS-1:0] raw,
    input  logic [NUM_FLAGS-1:0] pol,
    output logic [NUM_FLAGS-1:0] active
);
    genvar g;
    generate
        for (g = 0; g < NUM_FLAGS; g++) begin : g_flag
            // Invert the flag when it is low-true on the cable.
            assign active[g] = pol[g] ? raw[g] : ~raw[g];
        end
    endgenerate
endmodule

// File: rtl/camlink_tap_mask.sv
// Module: clears the ports not carried by the selected tap configuration.
// Assumes: NUM_PORTS > MEDIUM_PORTS; codes 2 and 3 both mean all ports live.
module camlink_tap_mask
    import camlink_pkg::*;
#(
    parameter int PORT_W    = 8,
    parameter int NUM_PORTS = 10
) (
    input  logic [1:0]                  taps,
    input  logic [PORT_W*NUM_PORTS-1:0] din,
    output logic [PORT_W*NUM_PORTS-1:0] dout
);
    logic use_medium;
    logic use_full;

    // Decode the configuration once for all ports.
    always_comb begin
        use_full   = (taps != TAPS_BASE) && (taps != TAPS_MEDIUM);
        use_medium = (taps != TAPS_BASE);
    end

    genvar p;
    generate
        for (p = 0; p < NUM_PORTS; p++) begin : g_port
            if (p < BASE_PORTS) begin : g_always
                assign dout[p*PORT_W +: PORT_W] = din[p*PORT_W +: PORT_W];
            end else if (p < MEDIUM_PORTS) begin : g_medium
                assign dout[p*PORT_W +: PORT_W] = use_medium ? din[p*PORT_W +: PORT_W] : '0;
            end else begin : g_full
                assign dout[p*PORT_W +: PORT_W] = use_full ? din[p*PORT_W +: PORT_W] : '0;
            end
        end
    endgenerate
endmodule

// File: rtl/camlink_lock_detect.sv
// Module: decides when the camera framing is trustworthy.
// Assumes: flags are active high and synchronous to clk; init is already synchronised.
// Area scan arms on a frame-valid rising edge; line scan is armed at once.
// Lock needs LINES_TO_LOCK line-valid falling edges after arming; it holds until reset.
module camlink_lock_detect
    import camlink_pkg::*;
#(
    parameter int LINES_TO_LOCK = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic linescan,
    input  logic fval,
    input  logic lval,
    output logic locked
);
    localparam int CNT_W = $clog2(LINES_TO_LOCK + 1);
    localparam logic [CNT_W-1:0] LAST_LINE = CNT_W'(LINES_TO_LOCK - 1);

    lock_state_e      state;
    logic             fval_d;
    logic             lval_d;
    logic             armed;
    logic [CNT_W-1:0] lines;
    logic             fval_rise;
    logic             lval_fall;

    // Edge detection on the normalised flags.
    always_comb begin
        fval_rise = fval && !fval_d;
        lval_fall = !lval && lval_d;
    end

    // Remember previous flag values in every state so no false edge appears at init.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fval_d <= 1'b0;
            lval_d <= 1'b0;
        end else begin
            fval_d <= fval;
            lval_d <= lval;
        end
    end

    // Detection state machine: idle, seeking framing, locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LK_IDLE;
            armed <= 1'b0;
            lines <= '0;
        end else begin
            case (state)
                LK_IDLE: begin
                    armed <= linescan;
                    lines <= '0;
                    if (init) state <= LK_SEEK;
                end
                LK_SEEK: begin
                    if (!init) begin
                        state <= LK_IDLE;
                        armed <= 1'b0;
                        lines <= '0;
                    end else if (!armed) begin
                        armed <= fval_rise;
                    end else if (lval_fall) begin
                        if (lines == LAST_LINE) state <= LK_LOCKED;
                        else                    lines <= lines + 1'b1;
                    end
                end
                LK_LOCKED: state <= LK_LOCKED;
                default:   state <= LK_IDLE;
            endcase
        end
    end

    assign locked = (state == LK_LOCKED);
endmodule

// File: rtl/camlink_async_fifo.sv
// Module: dual-clock FIFO with Gray-coded pointers and a self-popping read side.
// Assumes: AW >= 2. Every stored word is popped as soon as it is visible and
// yields exactly one rd_valid cycle; rd_data is meaningful only while rd_valid is high.
module camlink_async_fifo #(
    parameter int WIDTH = 84,
    parameter int AW    = 3,
    parameter int SYNC  = 2
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_full,
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wbin, wgray, rbin, rgray;
    logic [AW:0]      rgray_w, wgray_r;
    logic [AW:0]      wbin_nx, rbin_nx;
    logic             wr_go, rd_empty;

    function automatic logic [AW:0] to_gray(input logic [AW:0] b);
        return b ^ (b >> 1);
    endfunction

    // Full when write pointer is one lap ahead of the synchronised read pointer.
    always_comb begin
        wr_full = (wgray == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});
        wr_go   = wr_en && !wr_full;
        wbin_nx = wbin + 1'b1;
        rd_empty = (rgray == wgray_r);
        rbin_nx  = rbin + 1'b1;
    end

    // Write pointer update.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_go) begin
            wbin  <= wbin_nx;
            wgray <= to_gray(wbin_nx);
        end
    end

    // Storage write.
    always_ff @(posedge wr_clk) begin
        if (wr_go) mem[wbin[AW-1:0]] <= wr_data;
    end

    camlink_sync #(.WIDTH(AW + 1), .STAGES(SYNC)) u_rptr_sync (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_w)
    );

    camlink_sync #(.WIDTH(AW + 1), .STAGES(SYNC)) u_wptr_sync (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_r)
    );

    // Read pointer and strobe: pop one word per cycle whenever not empty.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rbin     <= '0;
            rgray    <= '0;
            rd_valid <= 1'b0;
        end else if (!rd_empty) begin
            rbin     <= rbin_nx;
            rgray    <= to_gray(rbin_nx);
            rd_valid <= 1'b1;
        end else begin
            rd_valid <= 1'b0;
        end
    end

    // Output register for the popped word.
    always_ff @(posedge rd_clk) begin
        if (!rd_empty) rd_data <= mem[rbin[AW-1:0]];
    end
endmodule

// File: rtl/camlink_rx_front.sv
// Module: Camera Link acquisition front end (top).
// Registers the pixel-domain inputs, normalises flag polarity, masks unused
// taps, detects lock and carries each locked pixel cycle to the image domain.
// Assumes: img_clk is faster than pix_clk; configuration is static outside
// reset; both resets are asserted together.
module camlink_rx_front
    import camlink_pkg::*;
#(
    parameter int PORT_W        = 8,
    parameter int NUM_PORTS     = 10,
    parameter int FIFO_AW       = 3,
    parameter int SYNC_STAGES   = 2,
    parameter int LINES_TO_LOCK = 2
) (
    input  logic                        pix_clk,
    input  logic                        pix_rst_n,
    input  logic [PORT_W*NUM_PORTS-1:0] cam_data,
    input  logic                        cam_fval,
    input  logic                        cam_lval,
    input  logic                        cam_dval,
    input  logic                        cam_spare,
    input  logic [1:0]                  cfg_taps,
    input  logic [NUM_FLAGS-1:0]        cfg_pol,
    input  logic                        cfg_linescan,
    input  logic                        img_clk,
    input  logic                        img_rst_n,
    input  logic                        acq_init,
    output logic                        acq_ready,
    output logic                        out_valid,
    output logic [PORT_W*NUM_PORTS-1:0] out_data,
    output logic [NUM_FLAGS-1:0]        out_flags
);
    localparam int DATA_W = PORT_W * NUM_PORTS;
    localparam int WORD_W = DATA_W + NUM_FLAGS;

    logic [DATA_W-1:0]    data_q;
    logic [NUM_FLAGS-1:0] flags_q;
    logic [NUM_FLAGS-1:0] flags_hi;
    logic [DATA_W-1:0]    data_m;
    logic                 init_pix;
    logic                 lock_det;
    logic                 fifo_full;
    logic [WORD_W-1:0]    rd_word;

    // Input register: one clean sample per pixel clock.
    always_ff @(posedge pix_clk) begin
        if (!pix_rst_n) begin
            data_q  <= '0;
            flags_q <= '0;
        end else begin
            data_q  <= cam_data;
            flags_q <= {cam_spare, cam_dval, cam_lval, cam_fval};
        end
    end

    camlink_flag_norm u_norm (
        .raw(flags_q), .pol(cfg_pol), .active(flags_hi)
    );

    camlink_tap_mask #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) u_mask (
        .taps(cfg_taps), .din(data_q), .dout(data_m)
    );

    camlink_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_init_sync (
        .clk(pix_clk), .rst_n(pix_rst_n), .d(acq_init), .q(init_pix)
    );

    camlink_lock_detect #(.LINES_TO_LOCK(LINES_TO_LOCK)) u_lock (
        .clk(pix_clk), .rst_n(pix_rst_n), .init(init_pix),
        .linescan(cfg_linescan),
        .fval(flags_hi[FLAG_FVAL]), .lval(flags_hi[FLAG_LVAL]),
        .locked(lock_det)
    );

    camlink_async_fifo #(.WIDTH(WORD_W), .AW(FIFO_AW), .SYNC(SYNC_STAGES)) u_xfer (
        .wr_clk(pix_clk), .wr_rst_n(pix_rst_n), .wr_en(lock_det),
        .wr_data({flags_hi, data_m}), .wr_full(fifo_full),
        .rd_clk(img_clk), .rd_rst_n(img_rst_n),
        .rd_valid(out_valid), .rd_data(rd_word)
    );

    camlink_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ready_sync (
        .clk(img_clk), .rst_n(img_rst_n), .d(lock_det), .q(acq_ready)
    );

    assign out_data  = rd_word[DATA_W-1:0];
    assign out_flags = rd_word[WORD_W-1:DATA_W];
endmodule

// File: rtl/camlink_rx_front_chk.sv
// Module: property checker for camlink_rx_front, attached with bind.
// Assumes: both resets are released together and configuration is static.
module camlink_rx_front_chk #(
    parameter int PORT_W    = 8,
    parameter int NUM_PORTS = 10
) (
    input logic                        pix_clk,
    input logic                        pix_rst_n,
    input logic                        img_clk,
    input logic                        img_rst_n,
    input logic [1:0]                  cfg_taps,
    input logic                        locked,
    input logic                        init_s,
    input logic                        fifo_full,
    input logic                        acq_ready,
    input logic                        out_valid,
    input logic [PORT_W*NUM_PORTS-1:0] out_data
);
    localparam int DATA_W = PORT_W * NUM_PORTS;

    // R1: base configuration leaves ports D..J at zero on the output side.
    assert_base_zero_R1: assert property (@(posedge img_clk) disable iff (!img_rst_n)
        (out_valid && cfg_taps == 2'd0) |-> (out_data[DATA_W-1:3*PORT_W] == '0));

    // R2: medium configuration leaves ports G..J at zero.
    assert_medium_zero_R2: assert property (@(posedge img_clk) disable iff (!img_rst_n)
        (out_valid && cfg_taps == 2'd1) |-> (out_data[DATA_W-1:6*PORT_W] == '0));

    // R7: lock can only be taken while init was seen high.
    assert_lock_needs_init_R7: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
        $rose(locked) |-> $past(init_s));

    // R8: ready never falls outside reset.
    assert_ready_sticky_R8: assert property (@(posedge img_clk) disable iff (!img_rst_n)
        acq_ready |=> acq_ready);

    // R9: no output word before ready.
    assert_valid_after_ready_R9: assert property (@(posedge img_clk) disable iff (!img_rst_n)
        out_valid |-> acq_ready);

    // R10: the crossing FIFO never fills while words are being pushed.
    assert_no_overflow_R10: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
        locked |-> !fifo_full);
endmodule

bind camlink_rx_front camlink_rx_front_chk #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) u_chk (
    .pix_clk(pix_clk), .pix_rst_n(pix_rst_n), .img_clk(img_clk), .img_rst_n(img_rst_n),
    .cfg_taps(cfg_taps), .locked(lock_det), .init_s(init_pix), .fifo_full(fifo_full),
    .acq_ready(acq_ready), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/camlink_rx_front_test.sv
// Bench: free-running synthetic camera (64-pixel frames of 8-pixel lines),
// table-driven configuration scenarios, then directed lock corner cases.
module camlink_rx_front_test;
    logic        pix_clk = 1'b0;
    logic        img_clk = 1'b0;
    logic        pix_rst_n = 1'b0;
    logic        img_rst_n = 1'b0;
    logic [79:0] cam_data;
    logic        cam_fval, cam_lval, cam_dval, cam_spare;
    logic [1:0]  cfg_taps = 2'd0;
    logic [3:0]  cfg_pol = 4'hF;
    logic        cfg_linescan = 1'b0;
    logic        acq_init = 1'b0;
    logic        acq_ready, out_valid;
    logic [79:0] out_data;
    logic [3:0]  out_flags;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [15:0] stream_n = 16'd0;
    int          stream_mode = 0;     // 0 normal, 1 frame valid stuck, 2 line valid stuck
    int          cur_live = 3;
    bit          have_prev = 1'b0;
    logic [15:0] last_n, first_n, mon_n;
    int          out_count = 0;
    bit          done = 1'b0;

    always #10 pix_clk = ~pix_clk;    // 50 MHz camera
    always #4  img_clk = ~img_clk;    // 125 MHz image clock

    camlink_rx_front uut (
        .pix_clk(pix_clk), .pix_rst_n(pix_rst_n), .cam_data(cam_data),
        .cam_fval(cam_fval), .cam_lval(cam_lval), .cam_dval(cam_dval), .cam_spare(cam_spare),
        .cfg_taps(cfg_taps), .cfg_pol(cfg_pol), .cfg_linescan(cfg_linescan),
        .img_clk(img_clk), .img_rst_n(img_rst_n), .acq_init(acq_init),
        .acq_ready(acq_ready), .out_valid(out_valid), .out_data(out_data), .out_flags(out_flags)
    );

    // Fields: live ports [10:7], taps [6:5], polarity [4:1], line scan [0].
    localparam logic [10:0] VEC [6] = '{
        {4'd3,  2'd0, 4'b1111, 1'b0},
        {4'd6,  2'd1, 4'b0000, 1'b0},
        {4'd10, 2'd2, 4'b0101, 1'b1},
        {4'd10, 2'd2, 4'b1010, 1'b0},
        {4'd3,  2'd0, 4'b0011, 1'b1},
        {4'd6,  2'd1, 4'b1100, 1'b1}
    };

    function automatic logic [3:0] logic_flags(input logic [15:0] m, input int mode);
        logic fv, lv;
        fv = (mode == 1) ? 1'b0 : (m[5:0] >= 6'd4);
        lv = (mode == 2) ? 1'b0 : (m[2:0] < 3'd6);
        return {m[1], m[0], lv, fv};
    endfunction

    function automatic logic [79:0] port_data(input logic [15:0] m, input int live);
        logic [79:0] d;
        d = '0;
        for (int k = 0; k < 10; k++) begin
            if (k < live) begin
                if (k == 0)      d[7:0]      = m[7:0];
                else if (k == 1) d[15:8]     = m[15:8];
                else             d[k*8 +: 8] = m[7:0] ^ (8'h11 * k[7:0]);
            end
        end
        return d;
    endfunction

    // Camera model: advance one pixel per pixel-clock falling edge.
    always @(negedge pix_clk) stream_n <= stream_n + 16'd1;

    always_comb begin
        logic [3:0] lf;
        lf = logic_flags(stream_n, stream_mode) ^ ~cfg_pol;
        cam_fval  = lf[0];
        cam_lval  = lf[1];
        cam_dval  = lf[2];
        cam_spare = lf[3];
        cam_data  = port_data(stream_n, 10);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Output monitor: ordering (R10), flag polarity (R3), tap masking (R1/R2).
    always @(negedge img_clk) begin
        if (out_valid) begin
            mon_n = {out_data[15:8], out_data[7:0]};
            if (have_prev)
                check(mon_n == last_n + 16'd1, "R10", "word sequence",
                      {64'd0, mon_n}, {64'd0, last_n + 16'd1});
            else
                first_n = mon_n;
            check(out_flags == logic_flags(mon_n, 0), "R3", "active-high flags",
                  {76'd0, out_flags}, {76'd0, logic_flags(mon_n, 0)});
            check(out_data == port_data(mon_n, cur_live), (cur_live == 3) ? "R1" : "R2",
                  "port masking", out_data, port_data(mon_n, cur_live));
            last_n = mon_n;
            have_prev = 1'b1;
            out_count++;
        end
    end

    task automatic wait_phase(input int p);
        do begin
            @(negedge pix_clk);
            #1;
        end while (stream_n[5:0] != p[5:0]);
    endtask

    task automatic apply_reset();
        @(negedge img_clk);
        acq_init  = 1'b0;
        pix_rst_n = 1'b0;
        img_rst_n = 1'b0;
        repeat (4) @(negedge pix_clk);
        @(negedge img_clk);
        pix_rst_n = 1'b1;
        img_rst_n = 1'b1;
        have_prev = 1'b0;
        out_count = 0;
        @(negedge img_clk);
        check(acq_ready == 1'b0, "R11", "ready after reset", {79'd0, acq_ready}, 80'd0);
        check(out_valid == 1'b0, "R11", "valid after reset", {79'd0, out_valid}, 80'd0);
    endtask

    task automatic set_init(input logic v);
        @(negedge img_clk);
        acq_init = v;
    endtask

    initial begin
        #1200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // Table-driven scenarios: configuration, lock timing, streaming.
        for (int i = 0; i < 6; i++) begin
            cur_live     = int'(VEC[i][10:7]);
            cfg_taps     = VEC[i][6:5];
            cfg_pol      = VEC[i][4:1];
            cfg_linescan = VEC[i][0];
            stream_mode  = 0;
            apply_reset();
            wait_phase(8);
            set_init(1'b1);
            wait_phase(62);
            @(negedge img_clk);
            check(acq_ready == cfg_linescan, cfg_linescan ? "R5" : "R4",
                  "ready before next frame edge", {79'd0, acq_ready}, {79'd0, cfg_linescan});
            wait_phase(40);
            @(negedge img_clk);
            check(acq_ready == 1'b1, cfg_linescan ? "R5" : "R4", "ready after lock",
                  {79'd0, acq_ready}, 80'd1);
            set_init(1'b0);
            repeat (100) @(negedge pix_clk);
            #1;
            check(acq_ready == 1'b1, "R8", "ready held after init low", {79'd0, acq_ready}, 80'd1);
            check(out_count > 0, "R10", "words delivered", 80'(out_count), 80'd1);
            check(16'(stream_n - last_n) <= 16'd8, "R10", "latency bound",
                  {64'd0, 16'(stream_n - last_n)}, 80'd8);
            check(out_count == int'(16'(last_n - first_n)) + 1, "R10", "word count",
                  80'(out_count), 80'(int'(16'(last_n - first_n)) + 1));
        end

        // Area scan with frame valid stuck inactive: no lock.
        cur_live = 10; cfg_taps = 2'd2; cfg_pol = 4'hF; cfg_linescan = 1'b0; stream_mode = 1;
        apply_reset();
        set_init(1'b1);
        repeat (200) @(negedge pix_clk);
        @(negedge img_clk);
        check(acq_ready == 1'b0, "R4", "no frame edge, no lock", {79'd0, acq_ready}, 80'd0);
        check(out_count == 0, "R9", "no output without lock", 80'(out_count), 80'd0);

        // Line scan with line valid stuck inactive: no lock.
        cfg_linescan = 1'b1; stream_mode = 2;
        apply_reset();
        set_init(1'b1);
        repeat (200) @(negedge pix_clk);
        @(negedge img_clk);
        check(acq_ready == 1'b0, "R6", "no line edge, no lock", {79'd0, acq_ready}, 80'd0);
        check(out_count == 0, "R9", "no output without lock", 80'(out_count), 80'd0);

        // Init dropped before a single line completes, then raised again.
        stream_mode = 0;
        apply_reset();
        wait_phase(8);
        set_init(1'b1);
        repeat (3) @(negedge pix_clk);
        set_init(1'b0);
        repeat (200) @(negedge pix_clk);
        @(negedge img_clk);
        check(acq_ready == 1'b0, "R7", "early init drop", {79'd0, acq_ready}, 80'd0);
        check(out_count == 0, "R9", "no output after early drop", 80'(out_count), 80'd0);
        set_init(1'b1);
        repeat (100) @(negedge pix_clk);
        @(negedge img_clk);
        check(acq_ready == 1'b1, "R7", "detection restarts", {79'd0, acq_ready}, 80'd1);
        check(out_count > 0, "R10", "words after relock", 80'(out_count), 80'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule